// File: doc/BRIEF.md
# Clock Output Park and Stop Gate

This block sits between a bank of free-running internal clocks and the output pad drivers of a clock generator. A fast system clock oversamples every incoming clock level. Each output is passed through or parked, and the gate's decision can only change while that output's own clock is in its low phase, so a stop or a restart never produces a shortened pulse. Single-ended outputs park low. Differential true/complement pairs park either with true driven high and complement released, or with both released. Per-pin output-enable signals model the tri-state condition.

Two sources can park outputs. The first is a power-down request, which must be seen high on two consecutive rising edges of the CPU complement clock before it takes effect. It parks every output. On release, the block waits for a PLL-lock indication and then restarts all outputs from one rising edge of the reference PCI clock. The second is a software run/stop bit from the register file. It parks only the outputs whose stop-enable bit is set. Per-output enable bits disable individual outputs.

Top module: `clkout_park_gate`

## Requirements
- R1: While reset is asserted, every single-ended output is 0 and every differential data and output-enable signal is 0.
- R2: A power-down request takes effect only after it has been sampled high on two consecutive rising edges of `cpu_c_smp`. A request seen on only one such edge parks nothing.
- R3: Once power-down is in effect, each single-ended output goes low at the end of its current high phase and stays low. Every high pulse on an output lasts exactly as long as the source high phase.
- R4: A differential pair changes between running and parked only on a high-to-low transition of its complement input. When parked by power-down with its `df_pd_tri` bit at 0, it drives true = 1 with `df_t_oe` = 1 and holds `df_c_oe` = 0.
- R5: When parked by power-down with its `df_pd_tri` bit at 1, both `df_t_oe` and `df_c_oe` of the pair are 0.
- R6: With `sw_run` = 0, every output whose stop-enable bit is 1 parks at its own next low phase. Returning `sw_run` to 1 restarts those outputs with full-width pulses.
- R7: Outputs whose stop-enable bit is 0 keep toggling while `sw_run` = 0.
- R8: A single-ended output whose enable bit is 0 is held low. A differential pair whose enable bit is 0 has both output enables at 0.
- R9: After the power-down request is released, outputs stay parked while `pll_lock` is 0. Once lock is seen, restart begins at the next rising edge of `pci_ref`.
- R10: After power-down release, the first restarted high pulses of all enabled single-ended outputs fall within two `pci_ref` periods of each other.
- R11: A differential pair parked by the software stop uses the shared `df_stop_tri` bit. A value of 0 gives true driven high with the complement released. A value of 1 releases both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| se_clk_in | input | N_SE | Free-running single-ended clock levels; bit 0 is the PCI reference |
| df_t_in | input | N_DIFF | Differential true clock levels |
| df_c_in | input | N_DIFF | Differential complement clock levels |
| cpu_c_smp | input | 1 | CPU complement clock used to qualify power-down |
| pci_ref | input | 1 | PCI clock used to align restart |
| pd_req | input | 1 | Power-down request, active high, synchronous to clk |
| pll_lock | input | 1 | PLL locked indication |
| sw_run | input | 1 | Software run bit: 0 stops stoppable outputs, 1 resumes |
| se_en | input | N_SE | Single-ended output enables |
| se_stop_en | input | N_SE | Single-ended stop-enable bits |
| df_en | input | N_DIFF | Differential output enables |
| df_stop_en | input | N_DIFF | Differential stop-enable bits |
| df_pd_tri | input | N_DIFF | Power-down park shape per pair: 0 true high, 1 both released |
| df_stop_tri | input | 1 | Software-stop park shape for all pairs, same encoding |
| se_clk_out | output | N_SE | Gated single-ended clocks |
| df_t_out | output | N_DIFF | Gated true data |
| df_c_out | output | N_DIFF | Gated complement data |
| df_t_oe | output | N_DIFF | True output enable |
| df_c_oe | output | N_DIFF | Complement output enable |

## Verification
Every output is registered once, so a change on a source level appears one clk later. A park decision becomes visible only after the controller register, the lane's run register (which updates in the source's low phase) and the output register have each been clocked. Power-down therefore surfaces at least two `cpu_c_smp` rising edges after the request, plus the wait for each lane's low phase. The bench steps a behavioural model once per clk with exactly the inputs that the coming edge will sample. It compares all outputs at the following falling edge, so each result is checked in the cycle it is due. Directed checks of park shapes, pulse widths and restart spread are taken at the end of windows long enough for every lane to have passed a low phase.

// File: rtl/clkpg_pkg.sv
package clkpg_pkg;
  typedef enum logic [1:0] {
    PG_RUN      = 2'd0,
    PG_DOWN     = 2'd1,
    PG_WAITLOCK = 2'd2,
    PG_ALIGN    = 2'd3
  } pg_state_e;
endpackage

// File: rtl/pg_ctrl.sv
module pg_ctrl
  import clkpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_clk,
  input  logic pci_ref,
  input  logic pd_req,
  input  logic pll_lock,
  output logic pd_active
);
  pg_state_e st_q, st_d;
  logic smp_q, pci_q, seen_q, seen_d;
  logic rise_smp, rise_pci;

  assign rise_smp = smp_clk & ~smp_q;
  assign rise_pci = pci_ref & ~pci_q;

  always_comb begin
    st_d   = st_q;
    seen_d = 1'b0;
    case (st_q)
      PG_RUN: begin
        seen_d = seen_q;
        if (rise_smp) begin
          if (pd_req && seen_q) begin
            st_d   = PG_DOWN;
            seen_d = 1'b0;
          end else begin
            seen_d = pd_req;
          end
        end
      end
      PG_DOWN:     if (!pd_req)  st_d = PG_WAITLOCK;
      PG_WAITLOCK: if (pll_lock) st_d = PG_ALIGN;
      PG_ALIGN:    if (rise_pci) st_d = PG_RUN;
      default:     st_d = PG_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PG_RUN;
      seen_q <= 1'b0;
      smp_q  <= 1'b0;
      pci_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      seen_q <= seen_d;
      smp_q  <= smp_clk;
      pci_q  <= pci_ref;
    end
  end

  assign pd_active = (st_q != PG_RUN);

  // R2: parking starts only after a second qualifying sample
  p_two_samples_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_active) |-> $past(pd_req && seen_q && smp_clk && !smp_q));

  // R9: no progress toward restart without lock
  p_hold_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PG_WAITLOCK && !pll_lock) |=> (st_q == PG_WAITLOCK));

  // R9: restart only on a PCI rising edge
  p_exit_on_pci_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active) |-> $past(pci_ref && !pci_q));
endmodule

// File: rtl/se_lane.sv
module se_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic park_req,
  output logic out
);
  logic run_q, run_d, out_q, out_d, upd_en;

  assign upd_en = ~src;

  always_comb begin
    run_d = run_q;
    if (upd_en) run_d = ~park_req;
    out_d = src & run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b1;
      out_q <= 1'b0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
    end
  end

  assign out = out_q;

  // R3: the gate moves only while the source is low
  p_gate_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_q) |-> !$past(src));

  // R3: a parked lane cannot raise its output
  p_parked_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !out_q);
endmodule

// File: rtl/df_lane.sv
module df_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic t_in,
  input  logic c_in,
  input  logic en,
  input  logic park_req,
  input  logic tri_park,
  output logic t_out,
  output logic c_out,
  output logic t_oe,
  output logic c_oe
);
  logic run_q, run_d, cprev_q, c_fall;
  logic t_q, c_q, toe_q, coe_q;
  logic t_d, c_d, toe_d, coe_d;

  assign c_fall = cprev_q & ~c_in;

  always_comb begin
    run_d = run_q;
    if (c_fall) run_d = ~park_req;
    if (!en) begin
      t_d = 1'b0; c_d = 1'b0; toe_d = 1'b0; coe_d = 1'b0;
    end else if (run_q) begin
      t_d = t_in; c_d = c_in; toe_d = 1'b1; coe_d = 1'b1;
    end else begin
      t_d = ~tri_park; toe_d = ~tri_park; c_d = 1'b0; coe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b1;
      cprev_q <= 1'b0;
      t_q     <= 1'b0;
      c_q     <= 1'b0;
      toe_q   <= 1'b0;
      coe_q   <= 1'b0;
    end else begin
      run_q   <= run_d;
      cprev_q <= c_in;
      t_q     <= t_d;
      c_q     <= c_d;
      toe_q   <= toe_d;
      coe_q   <= coe_d;
    end
  end

  assign t_out = t_q;
  assign c_out = c_q;
  assign t_oe  = toe_q;
  assign c_oe  = coe_q;

  // R4: run state changes only on a complement falling edge
  p_df_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_q) |-> $past(cprev_q && !c_in));

  // R4: a parked pair never drives its complement
  p_park_comp_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !coe_q);

  // R8: a disabled pair is fully released
  p_disabled_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!toe_q && !coe_q));
endmodule

// File: rtl/clkout_park_gate.sv
module clkout_park_gate #(
  parameter int N_SE   = 8,
  parameter int N_DIFF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SE-1:0]   se_clk_in,
  input  logic [N_DIFF-1:0] df_t_in,
  input  logic [N_DIFF-1:0] df_c_in,
  input  logic              cpu_c_smp,
  input  logic              pci_ref,
  input  logic              pd_req,
  input  logic              pll_lock,
  input  logic              sw_run,
  input  logic [N_SE-1:0]   se_en,
  input  logic [N_SE-1:0]   se_stop_en,
  input  logic [N_DIFF-1:0] df_en,
  input  logic [N_DIFF-1:0] df_stop_en,
  input  logic [N_DIFF-1:0] df_pd_tri,
  input  logic              df_stop_tri,
  output logic [N_SE-1:0]   se_clk_out,
  output logic [N_DIFF-1:0] df_t_out,
  output logic [N_DIFF-1:0] df_c_out,
  output logic [N_DIFF-1:0] df_t_oe,
  output logic [N_DIFF-1:0] df_c_oe
);
  logic pd_active;
  logic [N_SE-1:0]   se_park;
  logic [N_DIFF-1:0] df_park, df_tri;

  pg_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_clk  (cpu_c_smp),
    .pci_ref  (pci_ref),
    .pd_req   (pd_req),
    .pll_lock (pll_lock),
    .pd_active(pd_active)
  );

  assign se_park = {N_SE{pd_active}} | ({N_SE{~sw_run}} & se_stop_en) | ~se_en;
  assign df_park = {N_DIFF{pd_active}} | ({N_DIFF{~sw_run}} & df_stop_en);
  assign df_tri  = pd_active ? df_pd_tri : {N_DIFF{df_stop_tri}};

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    se_lane u_se (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (se_clk_in[i]),
      .park_req(se_park[i]),
      .out     (se_clk_out[i])
    );
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_df
    df_lane u_df (
      .clk     (clk),
      .rst_n   (rst_n),
      .t_in    (df_t_in[j]),
      .c_in    (df_c_in[j]),
      .en      (df_en[j]),
      .park_req(df_park[j]),
      .tri_park(df_tri[j]),
      .t_out   (df_t_out[j]),
      .c_out   (df_c_out[j]),
      .t_oe    (df_t_oe[j]),
      .c_oe    (df_c_oe[j])
    );
  end

  // R1: nothing is driven while reset is low
  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert ((se_clk_out == '0) && (df_t_oe == '0) && (df_c_oe == '0));
    end
  end
endmodule

// File: tb/sim_clkout_park_gate.sv
module sim_clkout_park_gate;
  localparam int NS = 8;
  localparam int ND = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic [NS-1:0] se_in, se_en, se_stop_en, se_out;
  logic [ND-1:0] dt_in, dc_in, df_en, df_stop_en, df_pd_tri;
  logic [ND-1:0] dt_out, dc_out, dt_oe, dc_oe;
  logic pd_req, pll_lock, sw_run, df_stop_tri;

  always #2.5 clk = ~clk;

  clkout_park_gate #(.N_SE(NS), .N_DIFF(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .se_clk_in(se_in), .df_t_in(dt_in), .df_c_in(dc_in),
    .cpu_c_smp(dc_in[0]), .pci_ref(se_in[0]), .pd_req(pd_req), .pll_lock(pll_lock),
    .sw_run(sw_run), .se_en(se_en), .se_stop_en(se_stop_en), .df_en(df_en),
    .df_stop_en(df_stop_en), .df_pd_tri(df_pd_tri), .df_stop_tri(df_stop_tri),
    .se_clk_out(se_out), .df_t_out(dt_out), .df_c_out(dc_out),
    .df_t_oe(dt_oe), .df_c_oe(dc_oe)
  );

  int checks = 0, fails = 0, scyc = 0, tcount = 0;
  string tag = "R1";
  bit mrun[NS], drun[ND], dcp[ND];
  int mst = 0;
  bit seen = 0, cprev = 0, pprev = 0;
  logic [NS-1:0] e_se, prev_out;
  logic [ND-1:0] e_t, e_c, e_toe, e_coe;
  int hw[NS], first_rise[NS];
  bit track_on = 0;

  function automatic int se_half(int i);
    return (i == 0) ? 6 : 2 + (i % 4);
  endfunction
  function automatic int df_half(int j);
    return 2 + (j % 3);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit pd_act, stop, fall, tri_s;
    pd_act = (mst != 0);
    for (int i = 0; i < NS; i++) begin
      e_se[i] = se_in[i] & mrun[i];
      stop = pd_act | (!sw_run & se_stop_en[i]) | !se_en[i];
      if (!se_in[i]) mrun[i] = !stop;
    end
    for (int j = 0; j < ND; j++) begin
      tri_s = pd_act ? df_pd_tri[j] : df_stop_tri;
      if (!df_en[j]) begin
        e_t[j] = 0; e_c[j] = 0; e_toe[j] = 0; e_coe[j] = 0;
      end else if (drun[j]) begin
        e_t[j] = dt_in[j]; e_c[j] = dc_in[j]; e_toe[j] = 1; e_coe[j] = 1;
      end else begin
        e_t[j] = !tri_s; e_toe[j] = !tri_s; e_c[j] = 0; e_coe[j] = 0;
      end
      fall = dcp[j] & !dc_in[j];
      stop = pd_act | (!sw_run & df_stop_en[j]);
      if (fall) drun[j] = !stop;
      dcp[j] = dc_in[j];
    end
    case (mst)
      0: if (dc_in[0] && !cprev) begin
           if (pd_req && seen) begin mst = 1; seen = 0; end
           else seen = pd_req;
         end
      1: begin seen = 0; if (!pd_req) mst = 2; end
      2: begin seen = 0; if (pll_lock) mst = 3; end
      default: begin seen = 0; if (se_in[0] && !pprev) mst = 0; end
    endcase
    cprev = dc_in[0];
    pprev = se_in[0];
  endtask

  task automatic set_levels();
    for (int i = 0; i < NS; i++) se_in[i] = ((scyc / se_half(i)) % 2) == 1;
    for (int j = 0; j < ND; j++) dc_in[j] = ((scyc / df_half(j)) % 2) == 1;
    dt_in = ~dc_in;
    scyc++;
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      set_levels();
      model_step();
      @(negedge clk);
      tcount++;
      chk({se_out, dt_out, dc_out, dt_oe, dc_oe} == {e_se, e_t, e_c, e_toe, e_coe}, tag,
          {24'd0, se_out, dt_out, dc_out, dt_oe, dc_oe}, {24'd0, e_se, e_t, e_c, e_toe, e_coe});
      for (int i = 0; i < NS; i++) begin
        if (se_out[i]) hw[i]++;
        else begin
          if (hw[i] > 0) chk(hw[i] == se_half(i), "R3 pulse width", hw[i], se_half(i));
          hw[i] = 0;
        end
        if (track_on && se_out[i] && !prev_out[i] && first_rise[i] < 0) first_rise[i] = tcount;
      end
      prev_out = se_out;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int tog_lo, tog_hi, mn, mx;
    logic [NS-1:0] acc;
    rst_n = 0; se_in = 0; dt_in = 0; dc_in = 0; pd_req = 0; pll_lock = 1; sw_run = 1;
    se_en = '1; se_stop_en = 8'h0F; df_en = '1; df_stop_en = 8'h3C; df_pd_tri = 8'hAA;
    df_stop_tri = 0; prev_out = 0;
    for (int i = 0; i < NS; i++) begin mrun[i] = 1; hw[i] = 0; first_rise[i] = -1; end
    for (int j = 0; j < ND; j++) begin drun[j] = 1; dcp[j] = 0; end
    e_se = 0; e_t = 0; e_c = 0; e_toe = 0; e_coe = 0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({se_out, dt_out, dc_out, dt_oe, dc_oe} == 40'd0, "R1 reset",
        {24'd0, se_out, dt_out, dc_out, dt_oe, dc_oe}, 64'd0);
    rst_n = 1;

    tag = "R7 free run"; step(60);

    // R6 / R7: software stop
    sw_run = 0; tag = "R6 stop"; step(30);
    acc = 0; tog_lo = 0;
    for (int k = 0; k < 30; k++) begin step(1); acc |= se_out; end
    chk(acc[3:0] == 4'h0, "R6 stoppable lanes parked", acc[3:0], 4'h0);
    chk(acc[7:4] == 4'hF, "R7 free lanes toggle", acc[7:4], 4'hF);
    // R11: stop park shape, true-high variant
    chk(dt_out[5:2] == 4'hF && dt_oe[5:2] == 4'hF && dc_oe[5:2] == 4'h0,
        "R11 stop park drive", {dt_out[5:2], dt_oe[5:2], dc_oe[5:2]}, 12'hFF0);
    df_stop_tri = 1; tag = "R11 stop tri"; step(20);
    chk(dt_oe[5:2] == 4'h0 && dc_oe[5:2] == 4'h0, "R11 stop park hiz",
        {dt_oe[5:2], dc_oe[5:2]}, 8'h00);
    sw_run = 1; tag = "R6 resume"; step(20);
    acc = 0;
    for (int k = 0; k < 20; k++) begin step(1); acc |= se_out; end
    chk(acc == 8'hFF, "R6 lanes resumed", acc, 8'hFF);

    // R2: single qualifying sample must not park
    tag = "R2 single sample"; pd_req = 1; step(4); pd_req = 0;
    acc = 0;
    for (int k = 0; k < 30; k++) begin step(1); acc |= se_out; end
    chk(acc == 8'hFF, "R2 no park on one sample", acc, 8'hFF);

    // R3 R4 R5: full power-down
    pd_req = 1; pll_lock = 0; tag = "R3 R4 R5 power-down"; step(60);
    chk(se_out == 0, "R3 single-ended parked low", se_out, 0);
    chk((dt_out & ~df_pd_tri) == ~df_pd_tri && (dt_oe & ~df_pd_tri) == ~df_pd_tri,
        "R4 true driven high", {dt_out, dt_oe}, {~df_pd_tri, ~df_pd_tri});
    chk(dc_oe == 0, "R4 complement released", dc_oe, 0);
    chk((dt_oe & df_pd_tri) == 0, "R5 both released", dt_oe & df_pd_tri, 0);

    // R9: waiting for lock
    pd_req = 0; tag = "R9 wait lock"; step(40);
    chk(se_out == 0 && dc_oe == 0, "R9 parked until lock", {se_out, dc_oe}, 0);

    // R10: restart spread
    for (int i = 0; i < NS; i++) first_rise[i] = -1;
    track_on = 1; pll_lock = 1; tag = "R9 R10 restart"; step(80); track_on = 0;
    mn = 1 << 30; mx = -1;
    for (int i = 0; i < NS; i++) begin
      if (first_rise[i] < mn) mn = first_rise[i];
      if (first_rise[i] > mx) mx = first_rise[i];
    end
    chk(mn >= 0 && (mx - mn) <= 2 * 2 * se_half(0), "R10 restart spread", mx - mn, 2 * 2 * se_half(0));

    // R8: enables
    se_en[5] = 0; df_en[6] = 0; tag = "R8 disable"; step(20);
    acc = 0;
    for (int k = 0; k < 20; k++) begin step(1); acc |= se_out; end
    chk(acc[5] == 0, "R8 single-ended held low", acc[5], 0);
    chk(dt_oe[6] == 0 && dc_oe[6] == 0, "R8 pair released", {dt_oe[6], dc_oe[6]}, 0);
    se_en = '1; df_en = '1; tag = "R8 re-enable"; step(30);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule